// File: doc/BRIEF.md
# Signature-Indexed Reuse Predictor

This block keeps a table of small saturating counters, one per access signature, and learns from them whether cache lines fetched under a signature tend to be touched again. A cache controller sends it three kinds of request. An increment request arrives when a resident line hits, and carries the signature the line was filled under. A decrement request arrives when a line leaves the cache without ever having been reused. A lookup request arrives on a miss, carries the signature of the incoming line, and gets back one prediction bit. The bit says the line should be inserted as distant when the indexed counter is zero, and as intermediate when the counter is positive.

Training can be limited to a sampled subset of cache sets. Each training request carries the set index of the line. When sampling is enabled, a request counts only if its set index has all of its low `SAMPLE_SHIFT` bits at zero. With 1024 sets and a shift of 4, that keeps 64 training sets. Lookups are never filtered, so every set gets predictions.

The signature width (and with it the table depth), the counter width, the set index width, the sampling ratio and whether sampling is used are all parameters. The prediction comes out one cycle after its lookup.

Top module: `sig_reuse_predictor`

## Requirements
- R1: After reset every counter holds the midpoint 2^(CTR_W-1)-1 (3 for 3-bit counters, 1 for 2-bit counters), so every lookup before any training predicts intermediate (`pred_distant`=0).
- R2: When `lkp_valid` is high, `pred_valid` is high in the next cycle. In that cycle `pred_distant` is 1 exactly when the counter indexed by `lkp_sig` is zero.
- R3: An accepted increment raises the indexed counter by one, up to the maximum 2^CTR_W-1. At the maximum it stays there and never wraps to zero.
- R4: An accepted decrement lowers the indexed counter by one, down to zero. At zero it stays there and never wraps to the maximum.
- R5: When an accepted increment and an accepted decrement name the same signature in one cycle, that counter is unchanged. When they name different signatures, both updates take effect.
- R6: A lookup in the same cycle as an update to the same counter reports the value from before that update.
- R7: With `SAMPLE_EN`=1, a training request whose set index has a nonzero value in its low `SAMPLE_SHIFT` bits has no effect on the table. Lookups ignore set indexes entirely.
- R8: `pred_distant` is 0 in every cycle in which `pred_valid` is 0, including during reset.

Design parameters: `SIG_W` (signature width; the table has 2^SIG_W entries), `CTR_W` (counter width, at least 2), `SET_W` (set index width), `SAMPLE_SHIFT` (number of low set-index bits that must be zero for a set to train), `SAMPLE_EN` (1 enables the sampling filter).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inc_valid | input | 1 | Increment request from a hit |
| inc_sig | input | SIG_W | Fill signature of the line that hit |
| inc_set | input | SET_W | Set index of the line that hit |
| dec_valid | input | 1 | Decrement request from an eviction of a line that was never reused |
| dec_sig | input | SIG_W | Fill signature of the evicted line |
| dec_set | input | SET_W | Set index of the evicted line |
| lkp_valid | input | 1 | Lookup request from a miss |
| lkp_sig | input | SIG_W | Signature of the incoming line |
| pred_valid | output | 1 | Prediction valid, one cycle after the lookup |
| pred_distant | output | 1 | 1 = insert as distant, 0 = insert as intermediate |

## Verification
The cycle that matters most is one in which a lookup and a training update reach the same counter. The other collision is an increment and a decrement to one entry in the same cycle. Both are provoked by directed cycles that hold a counter at 1 or 0 and hit it with every mix of increment, decrement and lookup. They are also provoked by random traffic drawn from a pool of only eight signatures, which makes collisions frequent. A bench model advances only after it has answered the lookup of the same cycle, and it cancels same-entry pairs. It judges each prediction against the value from before the update. Later lookups show whether a collision disturbed the counter.

// File: rtl/rp_pkg.sv
package rp_pkg;

  // One saturating step of a counter that runs from 0 to maxv.
  function automatic int sat_step(input int v, input bit up, input bit dn, input int maxv);
    int r;
    r = v;
    if (up && !dn && v < maxv) r = v + 1;
    if (dn && !up && v > 0)    r = v - 1;
    return r;
  endfunction

  // Value held by every counter after reset.
  function automatic int ctr_midpoint(input int ctr_w);
    return (1 << (ctr_w - 1)) - 1;
  endfunction

endpackage

// File: rtl/rp_sample_filter.sv
module rp_sample_filter #(
  parameter int SET_W        = 10,
  parameter int SAMPLE_SHIFT = 4,
  parameter bit SAMPLE_EN    = 1'b1
) (
  input  logic             req,
  input  logic [SET_W-1:0] set_idx,
  output logic             ok
);
  logic unused_set;
  assign unused_set = ^set_idx;

  generate
    if (SAMPLE_EN && SAMPLE_SHIFT > 0) begin : g_sampled
      assign ok = req && (set_idx[SAMPLE_SHIFT-1:0] == '0);
    end else begin : g_all
      assign ok = req;
    end
  endgenerate
endmodule

// File: rtl/rp_counter_table.sv
module rp_counter_table #(
  parameter int SIG_W = 10,
  parameter int CTR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_req,
  input  logic             inc_ok,
  input  logic [SIG_W-1:0] inc_sig,
  input  logic             dec_req,
  input  logic             dec_ok,
  input  logic [SIG_W-1:0] dec_sig,
  input  logic [SIG_W-1:0] rd_sig,
  output logic [CTR_W-1:0] rd_val
);
  localparam int DEPTH = 1 << SIG_W;
  localparam int CMAX  = (1 << CTR_W) - 1;
  localparam int CMID  = rp_pkg::ctr_midpoint(CTR_W);

  logic [CTR_W-1:0] ctr_q [DEPTH];

  // Named events, brought out for the assertions.
  logic cancel_evt;
  logic inc_apply;
  logic dec_apply;
  logic inc_dropped;
  assign cancel_evt  = inc_ok && dec_ok && (inc_sig == dec_sig);
  assign inc_apply   = inc_ok && !cancel_evt;
  assign dec_apply   = dec_ok && !cancel_evt;
  assign inc_dropped = inc_req && !inc_ok && !(dec_ok && dec_sig == inc_sig);

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      logic up_g;
      logic dn_g;
      assign up_g = inc_apply && (inc_sig == SIG_W'(g));
      assign dn_g = dec_apply && (dec_sig == SIG_W'(g));
      always_ff @(posedge clk) begin
        if (!rst_n)
          ctr_q[g] <= CTR_W'(CMID);
        else if (up_g || dn_g)
          ctr_q[g] <= CTR_W'(rp_pkg::sat_step(int'(ctr_q[g]), up_g, dn_g, CMAX));
      end
    end
  endgenerate

  assign rd_val = ctr_q[rd_sig];

  logic unused_dec_req;
  assign unused_dec_req = dec_req;

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_apply && ctr_q[inc_sig] == CTR_W'(CMAX)) |=> ctr_q[$past(inc_sig)] == CTR_W'(CMAX));

  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_apply && ctr_q[dec_sig] == '0) |=> ctr_q[$past(dec_sig)] == '0);

  assert_cancel_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_evt |=> ctr_q[$past(inc_sig)] == $past(ctr_q[inc_sig]));

  assert_unsampled_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    inc_dropped |=> ctr_q[$past(inc_sig)] == $past(ctr_q[inc_sig]));
endmodule

// File: rtl/rp_lookup.sv
module rp_lookup #(
  parameter int CTR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lkp_valid,
  input  logic [CTR_W-1:0] rd_val,
  output logic             pred_valid,
  output logic             pred_distant
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pred_valid   <= 1'b0;
      pred_distant <= 1'b0;
    end else begin
      pred_valid   <= lkp_valid;
      pred_distant <= lkp_valid && (rd_val == '0);
    end
  end

  assert_pred_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_valid |=> pred_valid);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_valid |-> !pred_distant);
endmodule

// File: rtl/sig_reuse_predictor.sv
module sig_reuse_predictor #(
  parameter int SIG_W        = 10,
  parameter int CTR_W        = 3,
  parameter int SET_W        = 10,
  parameter int SAMPLE_SHIFT = 4,
  parameter bit SAMPLE_EN    = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_valid,
  input  logic [SIG_W-1:0] inc_sig,
  input  logic [SET_W-1:0] inc_set,
  input  logic             dec_valid,
  input  logic [SIG_W-1:0] dec_sig,
  input  logic [SET_W-1:0] dec_set,
  input  logic             lkp_valid,
  input  logic [SIG_W-1:0] lkp_sig,
  output logic             pred_valid,
  output logic             pred_distant
);
  logic             inc_ok;
  logic             dec_ok;
  logic [CTR_W-1:0] rd_val;

  rp_sample_filter #(.SET_W(SET_W), .SAMPLE_SHIFT(SAMPLE_SHIFT), .SAMPLE_EN(SAMPLE_EN))
    u_inc_filt (.req(inc_valid), .set_idx(inc_set), .ok(inc_ok));

  rp_sample_filter #(.SET_W(SET_W), .SAMPLE_SHIFT(SAMPLE_SHIFT), .SAMPLE_EN(SAMPLE_EN))
    u_dec_filt (.req(dec_valid), .set_idx(dec_set), .ok(dec_ok));

  rp_counter_table #(.SIG_W(SIG_W), .CTR_W(CTR_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .inc_req(inc_valid), .inc_ok(inc_ok), .inc_sig(inc_sig),
    .dec_req(dec_valid), .dec_ok(dec_ok), .dec_sig(dec_sig),
    .rd_sig(lkp_sig), .rd_val(rd_val)
  );

  rp_lookup #(.CTR_W(CTR_W)) u_lookup (
    .clk(clk), .rst_n(rst_n), .lkp_valid(lkp_valid), .rd_val(rd_val),
    .pred_valid(pred_valid), .pred_distant(pred_distant)
  );

  assert_filter_needs_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_ok |-> inc_valid) and (dec_ok |-> dec_valid));
endmodule

// File: tb/sim_sig_reuse_predictor.sv
module sim_sig_reuse_predictor;
  localparam int SIG_W = 10;
  localparam int CTR_W = 3;
  localparam int SET_W = 10;
  localparam int SHIFT = 4;
  localparam int DEPTH = 1 << SIG_W;
  localparam int MAXV  = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inc_valid = 1'b0, dec_valid = 1'b0, lkp_valid = 1'b0;
  logic [SIG_W-1:0] inc_sig = '0, dec_sig = '0, lkp_sig = '0;
  logic [SET_W-1:0] inc_set = '0, dec_set = '0;
  logic pred_valid, pred_distant;

  int tests = 0;
  int fails = 0;
  int model [DEPTH];

  always #10 clk = ~clk;

  sig_reuse_predictor #(.SIG_W(SIG_W), .CTR_W(CTR_W), .SET_W(SET_W),
                        .SAMPLE_SHIFT(SHIFT), .SAMPLE_EN(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n),
    .inc_valid(inc_valid), .inc_sig(inc_sig), .inc_set(inc_set),
    .dec_valid(dec_valid), .dec_sig(dec_sig), .dec_set(dec_set),
    .lkp_valid(lkp_valid), .lkp_sig(lkp_sig),
    .pred_valid(pred_valid), .pred_distant(pred_distant));

  function automatic bit trains(input int set_idx);
    return (set_idx % (1 << SHIFT)) == 0;
  endfunction

  function automatic int bump(input int v, input int delta);
    int r;
    r = v + delta;
    if (r > MAXV) r = MAXV;
    if (r < 0) r = 0;
    return r;
  endfunction

  task automatic check(input bit cond, input string req, input int act, input int exp);
    tests++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at a negedge: drives one cycle, updates the model, checks at the next negedge.
  task automatic step(input bit iv, input int is, input int iset,
                      input bit dv, input int ds, input int dset,
                      input bit lv, input int ls, input string tag);
    bit exp_dist;
    bit ia, da;
    inc_valid = iv; inc_sig = SIG_W'(is); inc_set = SET_W'(iset);
    dec_valid = dv; dec_sig = SIG_W'(ds); dec_set = SET_W'(dset);
    lkp_valid = lv; lkp_sig = SIG_W'(ls);
    exp_dist = lv && (model[ls] == 0);
    ia = iv && trains(iset);
    da = dv && trains(dset);
    if (ia && da && is == ds) begin
      // same entry: no change
    end else begin
      if (ia) model[is] = bump(model[is], 1);
      if (da) model[ds] = bump(model[ds], -1);
    end
    @(posedge clk);
    @(negedge clk);
    check(pred_valid == lv, "R2 pred_valid", int'(pred_valid), int'(lv));
    if (lv) check(pred_distant == exp_dist, tag, int'(pred_distant), int'(exp_dist));
    else    check(!pred_distant, "R8 idle pred_distant", int'(pred_distant), 0);
  endtask

  task automatic look(input int s, input string tag);
    step(0, 0, 0, 0, 0, 0, 1, s, tag);
  endtask

  task automatic inc(input int s, input int set_idx);
    step(1, s, set_idx, 0, 0, 0, 0, 0, "R3");
  endtask

  task automatic dec(input int s, input int set_idx);
    step(0, 0, 0, 1, s, set_idx, 0, 0, "R4");
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < DEPTH; i++) model[i] = 3;
    lkp_valid = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!pred_valid && !pred_distant, "R8 reset outputs", int'(pred_valid), 0);
    rst_n = 1'b1;

    // R1: untrained entries are intermediate
    look(0, "R1 reset midpoint");
    look(5, "R1 reset midpoint");
    look(DEPTH - 1, "R1 reset midpoint");

    // R4: floor at zero, no wrap
    for (int k = 0; k < 4; k++) dec(7, 0);
    look(7, "R4 floor after 4 decs");
    inc(7, 16);
    look(7, "R4 one inc from zero");

    // R3: ceiling at max, no wrap
    for (int k = 0; k < 6; k++) inc(9, 32);
    for (int k = 0; k < 6; k++) dec(9, 0);
    look(9, "R3 still positive after 6 decs");
    dec(9, 0);
    look(9, "R3 zero after 7 decs");

    // R5: same-entry cancel, different entries both applied
    for (int k = 0; k < 5; k++) step(1, 20, 0, 1, 20, 16, 0, 0, "R5");
    for (int k = 0; k < 2; k++) dec(20, 0);
    look(20, "R5 cancel left value 3 (2 decs)");
    dec(20, 0);
    look(20, "R5 cancel left value 3 (3 decs)");
    step(1, 21, 0, 1, 22, 0, 0, 0, "R5");
    for (int k = 0; k < 2; k++) dec(22, 0);
    look(22, "R5 different entries dec applied");
    for (int k = 0; k < 4; k++) dec(21, 0);
    look(21, "R5 different entries inc applied");

    // R6: lookup sees pre-update value
    for (int k = 0; k < 2; k++) dec(30, 0);
    step(0, 0, 0, 1, 30, 0, 1, 30, "R6 lookup during dec to zero");
    look(30, "R6 value after dec");
    step(1, 30, 0, 0, 0, 0, 1, 30, "R6 lookup during inc from zero");
    look(30, "R6 value after inc");

    // R7: unsampled sets do not train, lookups unaffected
    for (int k = 0; k < 3; k++) dec(40, 0);
    inc(40, 1);
    inc(40, 15);
    step(1, 40, 17, 0, 0, 0, 1, 40, "R7 lookup ignores set");
    look(40, "R7 unsampled inc ignored");
    dec(41, 3);
    dec(41, 8);
    dec(41, 33);
    look(41, "R7 unsampled dec ignored");

    // Random traffic over a small signature pool
    for (int n = 0; n < 3000; n++) begin
      int s1, s2, s3, st1, st2;
      s1 = int'($urandom % 8);
      s2 = int'($urandom % 8);
      s3 = int'($urandom % 8);
      st1 = ($urandom % 4 != 0) ? int'(($urandom % 64) * 16) : int'($urandom % 1024);
      st2 = ($urandom % 4 != 0) ? int'(($urandom % 64) * 16) : int'($urandom % 1024);
      step(1'($urandom % 2), s1, st1, 1'($urandom % 2), s2, st2,
           1'($urandom % 2), s3, "R2 random lookup");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule